// File: doc/BRIEF.md
# Bridge Protection and Retry Supervisor

This block supervises the protection state of a driver with several power bridges. It receives already-digitised protection flags: one overcurrent flag per bridge, a die over-temperature flag and a supply undervoltage flag. It also receives an active-low run input that puts the driver to sleep. From these it produces one enable per bridge, an active-low open-drain style fault line and a global logic reset for the rest of the driver.

An overcurrent flag must persist through a deglitch window before it counts. A qualified overcurrent shuts down only its own bridge for a fixed retry period. The bridge is then re-armed, and the cycle repeats while the condition lasts. Over-temperature stops every bridge for as long as the flag is high. Undervoltage and sleep both hold the whole driver in logic reset. When either is released, a wake-up delay must pass before any bridge is enabled. All time windows are parameters counted in clock cycles.

Top module: `bridge_fault_sup`

## Requirements
- R1: While rst_ni is low, every bridge_en_o bit is 0, fault_no is 1 and logic_rst_o follows the sleep and undervoltage inputs. After rst_ni rises, the wake-up delay of R9 applies before any bridge is enabled.
- R2: An overcurrent flag qualifies only when it is sampled high on DEGLITCH_CYC+1 consecutive clock edges while the driver is awake. A pulse of DEGLITCH_CYC edges or fewer changes no output.
- R3: A qualified overcurrent on bridge b clears bridge_en_o[b] and pulls fault_no low from that same edge. Every other bridge keeps its enable.
- R4: A tripped bridge stays disabled for exactly RETRY_CYC clock edges. It is then re-enabled, and fault_no returns high if no other fault source is active.
- R5: If the overcurrent flag is still high after re-enable, the bridge trips again after another DEGLITCH_CYC+1 edges. This repeats for as long as the flag stays high.
- R6: While ot_i is high and the driver is not in logic reset, every bridge_en_o bit is 0 and fault_no is 0, with no clock delay. Both recover in the same cycle that ot_i falls.
- R7: While uv_i is high, logic_rst_o is 1, fault_no is 0 and every bridge is off. Any pending overcurrent trip is cleared.
- R8: While sleep_ni is low, logic_rst_o is 1 and every bridge is off. All protection inputs are ignored: fault_no stays 1 even with ot_i high, and overcurrent trips are cleared.
- R9: After logic reset ends, every bridge stays off for WAKE_CYC-1 clock edges and is enabled after the WAKE_CYC-th edge. Overcurrent deglitch counting starts only on the edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_ni | input | 1 | Run request; low puts the driver to sleep |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Die over-temperature flag |
| oc_i | input | NUM_BRIDGES | Per-bridge overcurrent flag |
| bridge_en_o | output | NUM_BRIDGES | Per-bridge enable |
| fault_no | output | 1 | Fault line, active low |
| logic_rst_o | output | 1 | Global logic reset for the driver |

## Verification
Over-temperature, undervoltage and sleep act on the outputs combinationally. They are checked shortly after the inputs change, with no clock edge in between. Overcurrent trip, retry release and wake-up completion are each due on a known edge: edge DEGLITCH_CYC+1 after the flag rises, edge RETRY_CYC after the trip, and edge WAKE_CYC after logic reset ends. The bench drives inputs just after a rising edge and samples outputs after every following edge. It checks both the cycle before each transition, where the old value must still hold, and the cycle of the transition itself. Pulse lengths from one edge up to the threshold are swept on each bridge in turn.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic {
    OC_RUN  = 1'b0,
    OC_TRIP = 1'b1
  } oc_state_e;
endpackage

// File: rtl/bfs_wake_timer.sv
module bfs_wake_timer #(
  parameter int unsigned WAKE_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == CW'(WAKE_CYC - 1)) rdy_q <= 1'b1;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;

  // R9
  wake_after_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(!clr_i));

  // R9
  wake_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ready_o);
endmodule

// File: rtl/bfs_oc_chan.sv
module bfs_oc_chan
  import bfs_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC = 1000,
  parameter int unsigned RETRY_CYC    = 337500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic oc_i,
  output logic trip_o
);
  localparam int unsigned DW = $clog2(DEGLITCH_CYC + 1);
  localparam int unsigned RW = $clog2(RETRY_CYC + 1);

  oc_state_e     st_q;
  logic [DW-1:0] dcnt_q;
  logic [RW-1:0] rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= OC_RUN;
      dcnt_q <= '0;
      rcnt_q <= '0;
    end else if (clr_i) begin
      st_q   <= OC_RUN;
      dcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      unique case (st_q)
        OC_RUN: begin
          if (arm_i && oc_i) begin
            if (dcnt_q == DW'(DEGLITCH_CYC)) begin
              st_q   <= OC_TRIP;
              dcnt_q <= '0;
              rcnt_q <= '0;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end else begin
            dcnt_q <= '0;
          end
        end
        OC_TRIP: begin
          if (rcnt_q == RW'(RETRY_CYC - 1)) st_q   <= OC_RUN;
          else                              rcnt_q <= rcnt_q + 1'b1;
        end
        default: st_q <= OC_RUN;
      endcase
    end
  end

  assign trip_o = (st_q == OC_TRIP);

  // R2
  trip_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> ($past(oc_i) && $past(arm_i)));

  // R4
  retry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clr_i && rcnt_q != RW'(RETRY_CYC - 1)) |=> trip_o);

  // R4
  retry_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clr_i && rcnt_q == RW'(RETRY_CYC - 1)) |=> !trip_o);
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup #(
  parameter int unsigned NUM_BRIDGES  = 2,
  parameter int unsigned DEGLITCH_CYC = 1000,
  parameter int unsigned RETRY_CYC    = 337500,
  parameter int unsigned WAKE_CYC     = 250000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sleep_ni,
  input  logic                   uv_i,
  input  logic                   ot_i,
  input  logic [NUM_BRIDGES-1:0] oc_i,
  output logic [NUM_BRIDGES-1:0] bridge_en_o,
  output logic                   fault_no,
  output logic                   logic_rst_o
);
  logic                   hold_rst;
  logic                   ready;
  logic [NUM_BRIDGES-1:0] trip;

  assign hold_rst = uv_i | ~sleep_ni;

  bfs_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hold_rst),
    .ready_o(ready)
  );

  for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_br
    bfs_oc_chan #(
      .DEGLITCH_CYC(DEGLITCH_CYC),
      .RETRY_CYC   (RETRY_CYC)
    ) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (hold_rst),
      .arm_i (ready),
      .oc_i  (oc_i[g]),
      .trip_o(trip[g])
    );

    assign bridge_en_o[g] = ready & ~hold_rst & ~ot_i & ~trip[g];

    // R3
    trip_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip[g] |-> !bridge_en_o[g]);
  end

  assign fault_no    = ~(uv_i | (~hold_rst & (ot_i | (|trip))));
  assign logic_rst_o = hold_rst;

  // R6
  ot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_i && sleep_ni) |-> (!fault_no && bridge_en_o == '0));

  // R7
  uv_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> (!fault_no && logic_rst_o && bridge_en_o == '0));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_ni && !uv_i) |-> (fault_no && logic_rst_o && bridge_en_o == '0));

  // R9
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(logic_rst_o) |-> bridge_en_o == '0);
endmodule

// File: tb/bridge_fault_sup_tb_top.sv
`timescale 1ns/1ps
module bridge_fault_sup_tb_top;
  localparam int NB = 2;
  localparam int DG = 3;
  localparam int RT = 8;
  localparam int WK = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          sleep_ni, uv_i, ot_i;
  logic [NB-1:0] oc_i;
  logic [NB-1:0] bridge_en_o;
  logic          fault_no, logic_rst_o;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  bridge_fault_sup #(
    .NUM_BRIDGES(NB), .DEGLITCH_CYC(DG), .RETRY_CYC(RT), .WAKE_CYC(WK)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_ni(sleep_ni), .uv_i(uv_i),
    .ot_i(ot_i), .oc_i(oc_i), .bridge_en_o(bridge_en_o),
    .fault_no(fault_no), .logic_rst_o(logic_rst_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string tag, logic [NB-1:0] e_en, logic e_fn, logic e_lr);
    #0.5;
    checks++;
    if (bridge_en_o !== e_en || fault_no !== e_fn || logic_rst_o !== e_lr) begin
      errs++;
      $display("FAIL %s: en=%b fault_n=%b lrst=%b expected en=%b fault_n=%b lrst=%b",
               tag, bridge_en_o, fault_no, logic_rst_o, e_en, e_fn, e_lr);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] all_on;
    all_on   = '1;
    rst_ni   = 1'b0;
    sleep_ni = 1'b1;
    uv_i     = 1'b0;
    ot_i     = 1'b0;
    oc_i     = '0;
    tick();
    tick();
    chk("R1 reset", '0, 1'b1, 1'b0);
    rst_ni = 1'b1;
    for (int k = 1; k <= WK; k++) begin
      tick();
      chk("R1 R9 power-up wake", (k < WK) ? '0 : all_on, 1'b1, 1'b0);
    end

    // R2: sweep glitch lengths on every bridge
    for (int b = 0; b < NB; b++) begin
      for (int l = 1; l <= DG; l++) begin
        oc_i[b] = 1'b1;
        for (int k = 0; k < l; k++) begin
          tick();
          chk("R2 glitch ignored", all_on, 1'b1, 1'b0);
        end
        oc_i[b] = 1'b0;
        tick();
        chk("R2 glitch ignored after", all_on, 1'b1, 1'b0);
      end
    end

    // R3 R4: trip and retry on each bridge alone
    for (int b = 0; b < NB; b++) begin
      logic [NB-1:0] others;
      others  = all_on & ~(NB'(1) << b);
      oc_i[b] = 1'b1;
      for (int k = 1; k <= DG + 1; k++) begin
        tick();
        chk("R3 trip edge", (k <= DG) ? all_on : others, (k <= DG), 1'b0);
      end
      oc_i[b] = 1'b0;
      for (int j = 1; j <= RT; j++) begin
        tick();
        chk("R4 retry window", (j < RT) ? others : all_on, (j == RT), 1'b0);
      end
    end

    // R5: held overcurrent on bridge 1 repeats the cycle
    oc_i[1] = 1'b1;
    repeat (DG + 1) tick();
    chk("R5 first trip", 2'b01, 1'b0, 1'b0);
    repeat (RT) tick();
    chk("R5 rearm", all_on, 1'b1, 1'b0);
    for (int k = 1; k <= DG + 1; k++) begin
      tick();
      chk("R5 second trip", (k <= DG) ? all_on : 2'b01, (k <= DG), 1'b0);
    end
    oc_i[1] = 1'b0;
    repeat (RT) tick();
    chk("R5 recover", all_on, 1'b1, 1'b0);

    // R3: both bridges at once, independent
    oc_i = '1;
    repeat (DG + 1) tick();
    chk("R3 both tripped", '0, 1'b0, 1'b0);
    oc_i = '0;
    repeat (RT) tick();
    chk("R3 both recovered", all_on, 1'b1, 1'b0);

    // R6: over-temperature
    ot_i = 1'b1;
    chk("R6 ot immediate", '0, 1'b0, 1'b0);
    tick();
    tick();
    chk("R6 ot held", '0, 1'b0, 1'b0);
    ot_i = 1'b0;
    chk("R6 ot released", all_on, 1'b1, 1'b0);

    // R7: undervoltage, overcurrent ignored, wake after
    uv_i    = 1'b1;
    oc_i[0] = 1'b1;
    chk("R7 uv immediate", '0, 1'b0, 1'b1);
    repeat (DG + 3) tick();
    chk("R7 uv held", '0, 1'b0, 1'b1);
    uv_i    = 1'b0;
    oc_i[0] = 1'b0;
    for (int k = 1; k <= WK; k++) begin
      tick();
      chk("R7 R9 wake after uv", (k < WK) ? '0 : all_on, 1'b1, 1'b0);
    end

    // R8: sleep clears a trip, ignores ot; R9 deglitch waits for wake
    oc_i[0] = 1'b1;
    repeat (DG + 1) tick();
    chk("R8 pre-sleep trip", 2'b10, 1'b0, 1'b0);
    sleep_ni = 1'b0;
    ot_i     = 1'b1;
    chk("R8 sleep entry", '0, 1'b1, 1'b1);
    repeat (3) tick();
    chk("R8 sleep ignores inputs", '0, 1'b1, 1'b1);
    sleep_ni = 1'b1;
    ot_i     = 1'b0;
    for (int k = 1; k <= WK; k++) begin
      tick();
      chk("R9 wake after sleep", (k < WK) ? '0 : all_on, 1'b1, 1'b0);
    end
    for (int k = 1; k <= DG + 1; k++) begin
      tick();
      chk("R9 deglitch after wake", (k <= DG) ? all_on : 2'b10, (k <= DG), 1'b0);
    end
    oc_i = '0;
    repeat (RT) tick();
    chk("R4 final recover", all_on, 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule